// File: doc/BRIEF.md
# GPIO Line Interrupt Event Detector

This block watches a bank of already-synchronized input lines and turns selected transitions or levels into pending interrupt events. Each line carries its own 3-bit detection code from the pin configuration logic. The code picks one of five conditions: rising edge, falling edge, either edge, low level or high level. A line counts as having an edge when its value differs from the value it held on the previous clock cycle.

Pending events collect in a status register. Software reads that register and the read also clears it, so no acknowledge write is needed. A mask decides which pending lines may raise the single bank interrupt. The mask is changed through separate set-bits and clear-bits write addresses and is read back at its own address. The status register records events whether or not the line is masked.

Top module: `gpio_evt_bank`

## Requirements
- R1: Detection codes 0 (falling), 1 (rising), 2 (either edge), 3 (low level) and 4 (high level) set the line's status bit at the first clock edge where the condition holds. An edge is the line's current value compared with its value one cycle earlier.
- R2: Detection codes 5, 6 and 7 never set a status bit.
- R3: A read at offset 0x2C returns the pending status and clears it on that read's clock edge. Reads at other offsets leave the status untouched.
- R4: An event detected in the same cycle as a status read is not lost. The read returns the earlier contents and the new bit stays set afterwards.
- R5: A level condition sets its status bit on every cycle it holds, so the bit is pending again right after a clearing read.
- R6: Writing 1s at offset 0x20 sets those mask bits, and writing 1s at offset 0x24 clears them. Reading offset 0x28 returns the mask.
- R7: Status bits are captured for masked lines exactly as for unmasked ones.
- R8: irq_o is high whenever some status bit is set and its mask bit is also set. It falls once such bits are cleared or masked.
- R9: After reset, the mask, the status and the previous-value history are all zero, and irq_o is low.
- R10: Writes to offsets 0x28, 0x2C or any unmapped offset change nothing, and reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lines_i | input | 32 | Synchronized input lines |
| evt_sel_i | input | 96 | Per-line 3-bit detection code, line n at bits 3n+2:3n |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid in the same cycle as reg_rd_i |
| irq_o | output | 1 | Combined bank interrupt |

## Verification
A line change driven between edges lands in the status register at the next rising edge. From that edge on it is visible on read data and, if the line is unmasked, on irq_o. Read data is combinational, so the bench raises the read strobe at a falling edge and samples 1 ns later. The status clear belongs to the following rising edge, which is why a read made right after a clearing read shows what survived. Mask writes take effect at the rising edge that ends the write cycle, and each check is sampled no earlier than the falling edge after that.

// File: rtl/gev_pkg.sv
package gev_pkg;
  localparam int unsigned SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    EV_FALL = 3'd0,
    EV_RISE = 3'd1,
    EV_BOTH = 3'd2,
    EV_LOW  = 3'd3,
    EV_HIGH = 3'd4
  } ev_code_e;

  localparam logic [7:0] OFS_MASK_SET = 8'h20;
  localparam logic [7:0] OFS_MASK_CLR = 8'h24;
  localparam logic [7:0] OFS_MASK_RD  = 8'h28;
  localparam logic [7:0] OFS_STATUS   = 8'h2C;
endpackage

// File: rtl/gev_detect.sv
module gev_detect
  import gev_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_LINES-1:0]       lines_i,
  input  logic [NUM_LINES*SEL_W-1:0] sel_i,
  output logic [NUM_LINES-1:0]       hit_o
);
  logic [NUM_LINES-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lines_i;
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic [SEL_W-1:0] sel;
    logic             rise, fall;
    assign sel  = sel_i[i*SEL_W +: SEL_W];
    assign rise = lines_i[i] & ~prev_q[i];
    assign fall = ~lines_i[i] & prev_q[i];

    always_comb begin
      case (sel)
        EV_FALL: hit_o[i] = fall;
        EV_RISE: hit_o[i] = rise;
        EV_BOTH: hit_o[i] = rise | fall;
        EV_LOW:  hit_o[i] = ~lines_i[i];
        EV_HIGH: hit_o[i] = lines_i[i];
        default: hit_o[i] = 1'b0;
      endcase
    end

    a_r2_reserved_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel > 3'd4) |-> !hit_o[i]);
    a_r5_level_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel == 3'd4 && lines_i[i] && $stable(sel)) |=> (sel != 3'd4) || !lines_i[i] || hit_o[i]);
  end
endmodule

// File: rtl/gev_status.sv
module gev_status #(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] hit_i,
  input  logic                 clr_i,
  output logic [NUM_LINES-1:0] status_o
);
  logic [NUM_LINES-1:0] status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (clr_i ? '0 : status_q) | hit_i;
  end

  assign status_o = status_q;

  a_r4_hit_survives: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i != '0) |=> ((status_o & $past(hit_i)) == $past(hit_i)));
  a_r3_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && hit_i == '0) |=> (status_o == '0));
  a_r3_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((status_o & $past(status_o)) == $past(status_o)));
endmodule

// File: rtl/gev_mask.sv
module gev_mask #(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] set_i,
  input  logic [NUM_LINES-1:0] clr_i,
  output logic [NUM_LINES-1:0] mask_o
);
  logic [NUM_LINES-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else         mask_q <= (mask_q & ~clr_i) | set_i;
  end

  assign mask_o = mask_q;

  a_r6_set_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((mask_o & $past(set_i)) == $past(set_i)));
  a_r6_clr_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i != '0 && set_i == '0) |=> ((mask_o & $past(clr_i)) == '0));
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i == '0 && clr_i == '0) |=> $stable(mask_o));
endmodule

// File: rtl/gpio_evt_bank.sv
module gpio_evt_bank
  import gev_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_LINES-1:0]       lines_i,
  input  logic [NUM_LINES*SEL_W-1:0] evt_sel_i,
  input  logic                       reg_wr_i,
  input  logic                       reg_rd_i,
  input  logic [ADDR_W-1:0]          reg_addr_i,
  input  logic [NUM_LINES-1:0]       reg_wdata_i,
  output logic [NUM_LINES-1:0]       reg_rdata_o,
  output logic                       irq_o
);
  localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(OFS_MASK_SET);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(OFS_MASK_CLR);
  localparam logic [ADDR_W-1:0] A_MSK = ADDR_W'(OFS_MASK_RD);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFS_STATUS);

  logic [NUM_LINES-1:0] hit_w, status_w, mask_w, mset_w, mclr_w;
  logic                 sts_rd_w;

  assign mset_w   = (reg_wr_i && reg_addr_i == A_SET) ? reg_wdata_i : '0;
  assign mclr_w   = (reg_wr_i && reg_addr_i == A_CLR) ? reg_wdata_i : '0;
  assign sts_rd_w = reg_rd_i && (reg_addr_i == A_STS);

  gev_detect #(.NUM_LINES(NUM_LINES)) u_detect (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lines_i(lines_i),
    .sel_i  (evt_sel_i),
    .hit_o  (hit_w)
  );

  gev_status #(.NUM_LINES(NUM_LINES)) u_status (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (hit_w),
    .clr_i   (sts_rd_w),
    .status_o(status_w)
  );

  gev_mask #(.NUM_LINES(NUM_LINES)) u_mask (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (mset_w),
    .clr_i (mclr_w),
    .mask_o(mask_w)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_rd_i) begin
      unique case (reg_addr_i)
        A_MSK:   reg_rdata_o = mask_w;
        A_STS:   reg_rdata_o = status_w;
        default: reg_rdata_o = '0;
      endcase
    end
  end

  assign irq_o = |(status_w & mask_w);

  a_r8_irq_follows_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((hit_w & mask_w & ~mclr_w) != '0) |=> irq_o);
  a_r7_masked_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((hit_w & ~mask_w) != '0) |=> ((status_w & $past(hit_w)) == $past(hit_w)));
  a_r9_quiet_after_reset: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (!irq_o && mask_w == '0));
endmodule

// File: tb/gpio_evt_bank_test.sv
module gpio_evt_bank_test;
  localparam int NL = 32;
  localparam int NV = 10;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NL-1:0] lines = '0;
  logic [NL*3-1:0] sel = '0;
  logic          wr = 1'b0, rd = 1'b0;
  logic [7:0]    addr = '0;
  logic [NL-1:0] wdata = '0;
  logic [NL-1:0] rdata;
  logic          irq;
  int            n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  gpio_evt_bank uut (
    .clk_i(clk), .rst_ni(rst_ni), .lines_i(lines), .evt_sel_i(sel),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  // code, line value before, line value after, expected status
  localparam logic [2:0]  V_CODE [NV] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5,
                                          3'd1, 3'd0, 3'd2, 3'd7};
  localparam logic [31:0] V_A [NV] = '{32'h0000FFFF, 32'h0000FFFF, 32'h0000FFFF,
                                       32'h0000FFFF, 32'h0000FFFF, 32'h0000FFFF,
                                       32'hF0F0F0F0, 32'hF0F0F0F0, 32'hF0F0F0F0,
                                       32'hF0F0F0F0};
  localparam logic [31:0] V_B [NV] = '{32'h00FF00FF, 32'h00FF00FF, 32'h00FF00FF,
                                       32'h00FF00FF, 32'h00FF00FF, 32'h00FF00FF,
                                       32'hFF00FF00, 32'hFF00FF00, 32'hFF00FF00,
                                       32'hFF00FF00};
  localparam logic [31:0] V_EXP [NV] = '{32'h0000FF00, 32'h00FF0000, 32'h00FFFF00,
                                         32'hFF00FF00, 32'h00FF00FF, 32'h00000000,
                                         32'h0F000F00, 32'h00F000F0, 32'h0FF00FF0,
                                         32'h00000000};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic all_sel(input logic [2:0] c);
    sel = {NL{c}};
  endtask

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    logic [31:0] d;
    all_sel(3'd7);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R9 reset state
    chk("R9 irq", {31'd0, irq}, 32'd0);
    reg_read(8'h28, d); chk("R9 mask", d, 32'd0);
    reg_read(8'h2C, d); chk("R9 status", d, 32'd0);

    // R6 mask set/clear/readback
    reg_write(8'h20, 32'h000000F0);
    reg_read(8'h28, d); chk("R6 set", d, 32'h000000F0);
    reg_write(8'h24, 32'h00000030);
    reg_read(8'h28, d); chk("R6 clear", d, 32'h000000C0);

    // R10 ignored writes, unmapped read
    reg_write(8'h28, 32'hFFFFFFFF);
    reg_write(8'h2C, 32'hFFFFFFFF);
    reg_write(8'h30, 32'hFFFFFFFF);
    reg_read(8'h28, d); chk("R10 mask kept", d, 32'h000000C0);
    reg_read(8'h2C, d); chk("R10 status kept", d, 32'd0);
    reg_read(8'h30, d); chk("R10 unmapped read", d, 32'd0);

    // R1/R2 vector table
    for (int v = 0; v < NV; v++) begin
      @(negedge clk); all_sel(3'd7); lines = V_A[v];
      repeat (2) @(negedge clk);
      reg_read(8'h2C, d);
      lines = V_B[v]; all_sel(V_CODE[v]);
      reg_read(8'h2C, d);
      chk(V_CODE[v] > 3'd4 ? "R2 reserved code" : "R1 detect", d, V_EXP[v]);
    end

    // R3 clear on read, other reads keep status
    @(negedge clk); all_sel(3'd7); lines = '0;
    repeat (2) @(negedge clk);
    reg_read(8'h2C, d);
    all_sel(3'd1); lines = 32'h3;
    @(negedge clk);
    reg_read(8'h28, d);
    reg_read(8'h2C, d); chk("R3 pending", d, 32'h3);
    reg_read(8'h2C, d); chk("R3 cleared", d, 32'h0);

    // R4 event in the read cycle
    lines = '0;
    repeat (2) @(negedge clk);
    reg_read(8'h2C, d);
    @(negedge clk); rd = 1'b1; addr = 8'h2C; lines = 32'h1;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
    chk("R4 read returns old", d, 32'h0);
    reg_read(8'h2C, d); chk("R4 new event kept", d, 32'h1);

    // R5 level re-pends
    @(negedge clk); all_sel(3'd4); lines = 32'h80;
    @(negedge clk);
    reg_read(8'h2C, d); chk("R5 first", d, 32'h80);
    reg_read(8'h2C, d); chk("R5 re-pend", d, 32'h80);

    // R7/R8 masked capture and irq (mask = 0xC0)
    @(negedge clk); all_sel(3'd7); lines = '0;
    repeat (2) @(negedge clk);
    reg_read(8'h2C, d);
    @(negedge clk);
    chk("R8 irq idle", {31'd0, irq}, 32'd0);
    all_sel(3'd1); lines = 32'h1;
    @(negedge clk);
    chk("R8 masked no irq", {31'd0, irq}, 32'd0);
    reg_read(8'h2C, d); chk("R7 masked captured", d, 32'h1);
    lines = 32'h41;
    @(negedge clk);
    chk("R8 irq raised", {31'd0, irq}, 32'd1);
    reg_write(8'h24, 32'h00000040);
    chk("R8 irq masked off", {31'd0, irq}, 32'd0);
    reg_write(8'h20, 32'h00000040);
    chk("R8 irq back", {31'd0, irq}, 32'd1);
    reg_read(8'h2C, d);
    @(negedge clk);
    chk("R8 irq after read", {31'd0, irq}, 32'd0);

    summary();
  end
endmodule